// File: doc/BRIEF.md
# Set/Clear Paired Control Register Bank

A 32-bit memory-mapped bank of control words. Four control registers (two reset-control, two clock-stop) are never overwritten directly: the register's own address ORs the written data in, and the word directly above it clears every bit that is 1 in the data. Two strap registers behave the same way, except that their set path is frozen while a protect word two words above the strap holds a non-zero value. The clear path of a strap is never frozen.

The bank also holds three PLL parameter/extension pairs. Reads of an extension word always show bit 31 high, which reports lock. It also holds a key word that records whether the unlock key was last written, read-only revision and identity words, and a random-data word that yields a fresh value on every read. The bus is word-aligned: one address, a write strobe, write data and a read-data register that is loaded every cycle from the addressed word. The control and strap values also drive output ports, so that neighbouring logic can use them directly.

Top module: `ctlbank_setclr`

## Requirements
- R1: After reset: reset-control A (0x40) = 0xF7C3FED8, reset-control B (0x50) = 0x0DFFFFFC, clock-stop A (0x80) = 0xFFFF7F8A, clock-stop B (0x90) = 0xFFF0FFF0, PLL parameter 0x200 = 0x1000408F, identity 0x5B0 = 0x1234ABCD and 0x5B4 = 0x88884444, revision 0x04 = REV_ID. Revision 0x14, the two straps and the key flag load from `rev2_init`, `strap_a_init`, `strap_b_init` and `lock_init`.
- R2: A write to 0x40, 0x50, 0x80 or 0x90 ORs the write data into that register. Data bits that are 0 leave the register unchanged.
- R3: A write to 0x44, 0x54, 0x84 or 0x94 clears, in the register one word below, each bit that is 1 in the data.
- R4: A write to strap 0x500 (or 0x510) ORs the data in only while the protect word at 0x508 (or 0x518) is zero. Otherwise the strap is unchanged.
- R5: A write to 0x504 (or 0x514) clears, in the strap one word below, each bit that is 1 in the data, whatever the protect word holds.
- R6: A read of PLL extension word 0x204, 0x224 or 0x244 returns the stored value with bit 31 forced to 1.
- R7: Writes to 0x04, 0x14, 0x540, 0x5B0 and 0x5B4 change nothing.
- R8: Each read of 0x540 returns a non-zero word that differs from the word returned by the previous cycle's read of 0x540.
- R9: A write to 0x00 sets the key flag (`unlocked`, and bit 0 when 0x00 is read) to 1 if the data equals UNLOCK_KEY and to 0 otherwise. The flag does not block writes to any register.
- R10: A write takes effect on the output ports one clock after its edge. `bus_rdata` is registered: it shows the addressed word as it stood before the write of the same edge, one cycle after the address is presented.
- R11: PLL parameter, PLL extension and protect words store full 32-bit writes. Every address not listed above, the clear addresses included, reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address, low two bits ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rev2_init | input | 32 | Reset value of revision word 0x14 |
| strap_a_init | input | 32 | Reset value of strap 0x500 |
| strap_b_init | input | 32 | Reset value of strap 0x510 |
| lock_init | input | 1 | Reset value of the key flag |
| rst_ctl_a | output | 32 | Reset-control A value |
| rst_ctl_b | output | 32 | Reset-control B value |
| clk_stop_a | output | 32 | Clock-stop A value |
| clk_stop_b | output | 32 | Clock-stop B value |
| strap_a | output | 32 | Strap A value |
| strap_b | output | 32 | Strap B value |
| unlocked | output | 1 | Key flag |

## Verification
On every cycle the assertions check the OR and AND-NOT updates of reset-control A, the freezing of strap A by its protect word, the lock bit on extension reads, the fixed identity read, the freshness of back-to-back random reads and the key comparison. Only the bench's scenarios show the full picture: bit-by-bit sweeps of set and clear across all four control registers, matched against a model in the bench; reset values that come from the input ports; strap B; writes to read-only words that leave them intact; and the lock flag leaving writes enabled.

// File: rtl/ctlbank_setclr.sv
module ctlbank_setclr #(
  parameter int          AW         = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
  parameter logic [31:0] REV_ID     = 32'h0503_0303
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   rev2_init,
  input  logic [31:0]   strap_a_init,
  input  logic [31:0]   strap_b_init,
  input  logic          lock_init,
  output logic [31:0]   rst_ctl_a,
  output logic [31:0]   rst_ctl_b,
  output logic [31:0]   clk_stop_a,
  output logic [31:0]   clk_stop_b,
  output logic [31:0]   strap_a,
  output logic [31:0]   strap_b,
  output logic          unlocked
);
  localparam int WA     = AW - 2;
  localparam int NCTL   = 4;
  localparam int NSTRAP = 2;
  localparam int NPLL   = 3;

  localparam logic [NCTL-1:0][WA-1:0] CTL_AT =
    {WA'(10'h024), WA'(10'h020), WA'(10'h014), WA'(10'h010)};
  localparam logic [NCTL-1:0][31:0] CTL_RST =
    {32'hFFF0_FFF0, 32'hFFFF_7F8A, 32'h0DFF_FFFC, 32'hF7C3_FED8};
  localparam logic [NSTRAP-1:0][WA-1:0] STRAP_AT = {WA'(10'h144), WA'(10'h140)};
  localparam logic [NPLL-1:0][WA-1:0] PLL_AT =
    {WA'(10'h090), WA'(10'h088), WA'(10'h080)};
  localparam logic [NPLL-1:0][31:0] PLL_RST =
    {32'h1004_077F, 32'h1008_405F, 32'h1000_408F};
  localparam logic [WA-1:0] A_KEY  = WA'(10'h000);
  localparam logic [WA-1:0] A_REV  = WA'(10'h001);
  localparam logic [WA-1:0] A_REV2 = WA'(10'h005);
  localparam logic [WA-1:0] A_RNG  = WA'(10'h150);
  localparam logic [WA-1:0] A_ID0  = WA'(10'h16C);
  localparam logic [WA-1:0] A_ID1  = WA'(10'h16D);
  localparam logic [31:0]   ID0    = 32'h1234_ABCD;
  localparam logic [31:0]   ID1    = 32'h8888_4444;
  localparam logic [31:0]   LFSR_TAPS = 32'hA300_0000;

  logic [WA-1:0] wa;
  logic [31:0]   ctl    [NCTL];
  logic [31:0]   strap  [NSTRAP];
  logic [31:0]   prot   [NSTRAP];
  logic [31:0]   pll_p  [NPLL];
  logic [31:0]   pll_x  [NPLL];
  logic [31:0]   rev2, rng, rd_mux;
  logic          key;

  assign wa = bus_addr[AW-1:2];

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    always_ff @(posedge clk)
      if (!rst_n)                                    ctl[g] <= CTL_RST[g];
      else if (bus_we && wa == CTL_AT[g])            ctl[g] <= ctl[g] | bus_wdata;
      else if (bus_we && wa == CTL_AT[g] + WA'(1))   ctl[g] <= ctl[g] & ~bus_wdata;
  end

  for (genvar g = 0; g < NSTRAP; g++) begin : g_strap
    always_ff @(posedge clk)
      if (!rst_n) begin
        strap[g] <= (g == 0) ? strap_a_init : strap_b_init;
        prot[g]  <= '0;
      end else if (bus_we) begin
        if (wa == STRAP_AT[g] && prot[g] == '0)  strap[g] <= strap[g] | bus_wdata;
        if (wa == STRAP_AT[g] + WA'(1))          strap[g] <= strap[g] & ~bus_wdata;
        if (wa == STRAP_AT[g] + WA'(2))          prot[g]  <= bus_wdata;
      end
  end

  for (genvar g = 0; g < NPLL; g++) begin : g_pll
    always_ff @(posedge clk)
      if (!rst_n) begin
        pll_p[g] <= PLL_RST[g];
        pll_x[g] <= '0;
      end else if (bus_we) begin
        if (wa == PLL_AT[g])          pll_p[g] <= bus_wdata;
        if (wa == PLL_AT[g] + WA'(1)) pll_x[g] <= bus_wdata;
      end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      key  <= lock_init;
      rev2 <= rev2_init;
      rng  <= 32'h6A09_E667;
    end else begin
      if (bus_we && wa == A_KEY) key <= (bus_wdata == UNLOCK_KEY);
      if (!bus_we && wa == A_RNG)
        rng <= (rng >> 1) ^ (rng[0] ? LFSR_TAPS : 32'h0);
    end

  always_comb begin
    rd_mux = '0;
    if (wa == A_KEY)  rd_mux = {31'b0, key};
    if (wa == A_REV)  rd_mux = REV_ID;
    if (wa == A_REV2) rd_mux = rev2;
    if (wa == A_RNG)  rd_mux = rng;
    if (wa == A_ID0)  rd_mux = ID0;
    if (wa == A_ID1)  rd_mux = ID1;
    for (int i = 0; i < NCTL; i++)
      if (wa == CTL_AT[i]) rd_mux = ctl[i];
    for (int i = 0; i < NSTRAP; i++) begin
      if (wa == STRAP_AT[i])          rd_mux = strap[i];
      if (wa == STRAP_AT[i] + WA'(2)) rd_mux = prot[i];
    end
    for (int i = 0; i < NPLL; i++) begin
      if (wa == PLL_AT[i])          rd_mux = pll_p[i];
      if (wa == PLL_AT[i] + WA'(1)) rd_mux = pll_x[i] | 32'h8000_0000;
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;

  assign rst_ctl_a  = ctl[0];
  assign rst_ctl_b  = ctl[1];
  assign clk_stop_a = ctl[2];
  assign clk_stop_b = ctl[3];
  assign strap_a    = strap[0];
  assign strap_b    = strap[1];
  assign unlocked   = key;
endmodule

// File: rtl/ctlbank_setclr_chk.sv
module ctlbank_setclr_chk #(
  parameter int          AW         = 12,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [31:0]   rst_ctl_a,
  input logic [31:0]   strap_a,
  input logic [31:0]   prot_a,
  input logic          unlocked
);
  logic [AW-3:0] wa;
  logic          rd_ext;
  assign wa     = bus_addr[AW-1:2];
  assign rd_ext = (wa == (AW-2)'(10'h081)) || (wa == (AW-2)'(10'h089)) ||
                  (wa == (AW-2)'(10'h091));

  AST_CTL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && wa == (AW-2)'(10'h010) |=> rst_ctl_a == ($past(rst_ctl_a) | $past(bus_wdata))); // R2
  AST_CTL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && wa == (AW-2)'(10'h011) |=> rst_ctl_a == ($past(rst_ctl_a) & ~$past(bus_wdata))); // R3
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && wa == (AW-2)'(10'h140) && prot_a != 32'h0 |=> $stable(strap_a)); // R4
  AST_PLL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ext |=> bus_rdata[31]); // R6
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wa == (AW-2)'(10'h16C) |=> bus_rdata == 32'h1234_ABCD); // R7
  AST_RNG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && wa == (AW-2)'(10'h150)) ##1 (!bus_we && wa == (AW-2)'(10'h150))
    |=> bus_rdata != $past(bus_rdata) && bus_rdata != 32'h0); // R8
  AST_KEY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && wa == (AW-2)'(10'h000) |=> unlocked == ($past(bus_wdata) == UNLOCK_KEY)); // R9
endmodule

bind ctlbank_setclr ctlbank_setclr_chk #(.AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_ctl_a(rst_ctl_a),
  .strap_a(strap_a), .prot_a(prot[0]), .unlocked(unlocked));

// File: tb/sim_ctlbank_setclr.sv
`timescale 1ns/1ps
module sim_ctlbank_setclr;
  localparam logic [31:0] KEY = 32'h1688_A8A8;
  localparam logic [31:0] REV = 32'h0503_0303;

  logic        clk = 0, rst_n = 0, bus_we = 0, lock_init = 1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] rev2_init = 32'h0503_0403, sa_init = 32'h0000_F0C3, sb_init = 32'h0101_0000;
  logic [31:0] rst_ctl_a, rst_ctl_b, clk_stop_a, clk_stop_b, strap_a, strap_b;
  logic        unlocked;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ctlbank_setclr u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rev2_init(rev2_init),
    .strap_a_init(sa_init), .strap_b_init(sb_init), .lock_init(lock_init),
    .rst_ctl_a(rst_ctl_a), .rst_ctl_b(rst_ctl_b), .clk_stop_a(clk_stop_a),
    .clk_stop_b(clk_stop_b), .strap_a(strap_a), .strap_b(strap_b), .unlocked(unlocked));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_out(int i);
    case (i)
      0: return rst_ctl_a;
      1: return rst_ctl_b;
      2: return clk_stop_a;
      default: return clk_stop_b;
    endcase
  endfunction

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, prev, m[4];
    logic [11:0] base[4];
    base[0] = 12'h040; base[1] = 12'h050; base[2] = 12'h080; base[3] = 12'h090;
    m[0] = 32'hF7C3_FED8; m[1] = 32'h0DFF_FFFC; m[2] = 32'hFFFF_7F8A; m[3] = 32'hFFF0_FFF0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < 4; i++) chk("R1 ctl reset", ctl_out(i), m[i]);
    chk("R1 strap a reset", strap_a, sa_init);
    chk("R1 strap b reset", strap_b, sb_init);
    chk("R1 lock reset", {31'b0, unlocked}, 32'h1);
    rd(12'h200, v); chk("R1 pll reset", v, 32'h1000_408F);
    rd(12'h5B0, v); chk("R1 id0 reset", v, 32'h1234_ABCD);
    rd(12'h5B4, v); chk("R1 id1 reset", v, 32'h8888_4444);
    rd(12'h004, v); chk("R1 rev reset", v, REV);
    rd(12'h014, v); chk("R1 rev2 reset", v, rev2_init);

    // R2/R3 sweep: walk single bits and patterns through every set and clear address
    for (int i = 0; i < 4; i++) begin
      for (int b = 0; b < 32; b++) begin
        logic [31:0] d;
        d = 32'h1 << b;
        wr(base[i] + 12'h4, d); m[i] &= ~d;
        chk("R3 clear bit", ctl_out(i), m[i]);
        wr(base[i], (b % 3 == 0) ? d : 32'h0); if (b % 3 == 0) m[i] |= d;
        chk("R2 set bit", ctl_out(i), m[i]);
      end
      wr(base[i], 32'h0F0F_5A5A); m[i] |= 32'h0F0F_5A5A;
      rd(base[i], v); chk("R10 readback after set", v, m[i]);
      wr(base[i] + 12'h4, 32'hFFFF_0000); m[i] &= 32'h0000_FFFF;
      chk("R3 clear upper half", ctl_out(i), m[i]);
      rd(base[i] + 12'h4, v); chk("R11 clear address reads zero", v, 32'h0);
    end

    // R10: pre-write value seen on rdata for same-edge write
    bus_addr = 12'h040; bus_wdata = 32'hFFFF_FFFF; bus_we = 1;
    @(negedge clk); bus_we = 0;
    chk("R10 rdata pre-write", bus_rdata, m[0]);
    m[0] = 32'hFFFF_FFFF;
    chk("R10 port next cycle", rst_ctl_a, m[0]);

    // R4/R5 straps
    wr(12'h500, 32'h0000_0F00); chk("R4 strap a set unprotected", strap_a, sa_init | 32'h0F00);
    wr(12'h508, 32'h1);
    rd(12'h508, v); chk("R11 protect readback", v, 32'h1);
    wr(12'h500, 32'hFFFF_0000); chk("R4 strap a set blocked", strap_a, sa_init | 32'h0F00);
    wr(12'h504, 32'h0000_00FF); chk("R5 strap a clear while protected", strap_a, (sa_init | 32'h0F00) & ~32'hFF);
    wr(12'h518, 32'h8000_0000);
    wr(12'h510, 32'h0000_0001); chk("R4 strap b set blocked", strap_b, sb_init);
    wr(12'h514, 32'h0001_0000); chk("R5 strap b clear", strap_b, sb_init & ~32'h0001_0000);
    wr(12'h518, 32'h0);
    wr(12'h510, 32'h0000_0001); chk("R4 strap b set after unprotect", strap_b, (sb_init & ~32'h0001_0000) | 32'h1);

    // R6/R11 pll
    for (int k = 0; k < 3; k++) begin
      logic [11:0] pa;
      pa = 12'h200 + 12'(k * 32);
      wr(pa + 12'h4, 32'h0000_1234 + k);
      rd(pa + 12'h4, v); chk("R6 ext lock bit", v, 32'h8000_1234 + k);
      wr(pa, 32'hCAFE_0000 + k);
      rd(pa, v); chk("R11 pll param store", v, 32'hCAFE_0000 + k);
    end
    rd(12'h300, v); chk("R11 unmapped reads zero", v, 32'h0);

    // R7 read-only words
    wr(12'h004, 32'h0); rd(12'h004, v); chk("R7 rev ro", v, REV);
    wr(12'h014, 32'h0); rd(12'h014, v); chk("R7 rev2 ro", v, rev2_init);
    wr(12'h5B0, 32'h0); rd(12'h5B0, v); chk("R7 id0 ro", v, 32'h1234_ABCD);
    wr(12'h5B4, 32'h0); rd(12'h5B4, v); chk("R7 id1 ro", v, 32'h8888_4444);

    // R8 random
    rd(12'h540, prev);
    wr(12'h540, 32'h0);
    for (int n = 0; n < 16; n++) begin
      rd(12'h540, v);
      checks++;
      if (v == prev || v == 32'h0) begin
        fails++;
        $display("FAIL R8 random repeat actual=%h expected!=%h", v, prev);
      end
      prev = v;
    end

    // R9 key
    wr(12'h000, KEY ^ 32'h1); chk("R9 wrong key locks", {31'b0, unlocked}, 32'h0);
    rd(12'h000, v); chk("R9 key readback", v, 32'h0);
    wr(12'h050, 32'hF000_0000); m[1] |= 32'hF000_0000;
    chk("R9 locked does not block", rst_ctl_b, m[1]);
    wr(12'h000, KEY); chk("R9 key unlocks", {31'b0, unlocked}, 32'h1);
    rd(12'h000, v); chk("R9 key readback one", v, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule